// File: doc/BRIEF.md
# ISA Slave I/O Decoder

This block sits behind the I/O side of an ISA-style expansion bus and turns host port reads and writes into single-cycle requests on a simple internal register port. A 10-bit port address is tested against a configurable window, given as a base and a span. The host strobes count only when the address-enable line shows an ordinary I/O cycle rather than a DMA cycle. The active-low read and write strobes are brought into the internal clock domain, and each falling edge starts exactly one register access.

The 16-bit claim output is a combinational decode of the address and the address-enable line alone. The read and write strobes do not affect it. A configuration bit can keep the claim deasserted, so that the motherboard splits every access into 8-bit cycles. The channel-ready output goes low as soon as a qualified strobe arrives. It stays low through a programmable number of wait cycles and the register port's one-cycle read latency. It returns high once read data is on the bus or write data has been captured.

Top module: `isa_io_decoder`

## Requirements
- R1: An access is qualified only while `dma_cycle_i` is low and `(io_addr_i - cfg_base_i) mod 1024 < cfg_span_i`. A span of zero qualifies nothing, and a window that runs past 0x3FF wraps to 0x000.
- R2: `wide_claim_no` is low exactly when the address is qualified per R1 and `cfg_wide_en_i` is 1. It does not change when a strobe is asserted.
- R3: While `cfg_wide_en_i` is 0, `wide_claim_no` stays high for every address.
- R4: A qualified fall of `rd_strobe_ni` gives exactly one `reg_re_o` pulse, with `reg_addr_o` equal to the offset from the base. `data_o` then carries the `reg_rdata_i` value from the cycle after that pulse, and `data_oe_o` is high while the qualified read strobe is low.
- R5: A qualified fall of `wr_strobe_ni` gives exactly one `reg_we_o` pulse, with `reg_addr_o` equal to the offset from the base and `reg_wdata_o` equal to `data_i` as seen when the access started.
- R6: A strobe with `dma_cycle_i` high, or with the address outside the window, gives no `reg_re_o` or `reg_we_o` pulse. `chan_ready_o` stays high during that strobe.
- R7: `chan_ready_o` goes low in the same cycle that a qualified strobe goes low. It goes high again only after the read data is valid or the write data is captured, and it stays high until the strobe is released.
- R8: Each increase of 1 in `cfg_wait_i` makes the low phase of `chan_ready_o` exactly one clock cycle longer.
- R9: A strobe held low for any length of time starts only one access. A new access needs the strobe to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 10 | Host I/O port address |
| dma_cycle_i | input | 1 | High during DMA cycles; blocks all decode |
| rd_strobe_ni | input | 1 | Host I/O read strobe, active low |
| wr_strobe_ni | input | 1 | Host I/O write strobe, active low |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Read data presented to the host |
| data_oe_o | output | 1 | Enable for the read data driver |
| wide_claim_no | output | 1 | 16-bit access claim, active low |
| chan_ready_o | output | 1 | Channel ready toward the host; low extends the cycle |
| cfg_base_i | input | 10 | Window base address |
| cfg_span_i | input | 10 | Window size in ports |
| cfg_wide_en_i | input | 1 | 1 allows the 16-bit claim; 0 forces 8-bit I/O |
| cfg_wait_i | input | 4 | Extra wait cycles before the register access |
| reg_addr_o | output | 10 | Register port offset |
| reg_wdata_o | output | 16 | Register port write data |
| reg_we_o | output | 1 | Register write pulse |
| reg_re_o | output | 1 | Register read pulse |
| reg_rdata_i | input | 16 | Register read data, valid one cycle after `reg_re_o` |

## Verification
The hardest case to reach is a strobe held low long after the ready phase has ended. While the handshake still sits in its hold state, the strobe must not start a second access. The bench holds every strobe for several cycles after ready rises. A scoreboard flags any register pulse that has no expected item queued for it, so a second access shows up as an unexpected pulse. The wrapped window is reached by moving the base near the top of the port space and then accessing a low address. The wait-cycle rule is checked by comparing ready-low lengths measured under different wait settings, so the check does not depend on the absolute latency.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACCESS,
    ST_CAPT,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/isa_io_window.sv
module isa_io_window #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] span_i,
  input  logic              dma_i,
  input  logic              wide_en_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic              claim_no
);
  // modular offset lets a window wrap past the top of the port space
  assign offset_o = addr_i - base_i;
  assign hit_o    = !dma_i && (offset_o < span_i);
  // pure address decode: strobes never enter here
  assign claim_no = !(hit_o && wide_en_i);
endmodule

// File: rtl/isa_io_sync.sv
module isa_io_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic rd_fall_o,
  output logic wr_fall_o,
  output logic idle_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] fall;
  logic [NCH-1:0] level;

  assign raw = {wr_ni, rd_ni};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '1;
        prev_q <= 1'b1;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], raw[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end
    assign level[g] = sh_q[STAGES-1];
    assign fall[g]  = prev_q && !sh_q[STAGES-1];
  end

  assign rd_fall_o = fall[0];
  assign wr_fall_o = fall[1];
  assign idle_o    = &level;

  // R9: one edge event per strobe assertion
  a_r9_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fall_o |=> !rd_fall_o);
  a_r9_single_wfall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fall_o |=> !wr_fall_o);
endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fall_i,
  input  logic              wr_fall_i,
  input  logic              idle_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              is_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      is_wr_q     <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hit_i && (rd_fall_i || wr_fall_i)) begin
            is_wr_q    <= !rd_fall_i;  // read wins a tie
            reg_addr_o <= offset_i;
            if (!rd_fall_i) reg_wdata_o <= wdata_i;
            cnt_q      <= wait_i;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_ACCESS;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_ACCESS: state_q <= is_wr_q ? ST_HOLD : ST_CAPT;
        ST_CAPT: begin
          rdata_o <= reg_rdata_i;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (idle_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_re_o = (state_q == ST_ACCESS) && !is_wr_q;
  assign reg_we_o = (state_q == ST_ACCESS) && is_wr_q;
  assign done_o   = (state_q == ST_HOLD);

  // R4: read pulse lasts one cycle and data is not yet flagged ready
  a_r4_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o && !done_o);
  // R5: write data counts as latched right after the pulse
  a_r5_wr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o && done_o);
endmodule

// File: rtl/isa_io_decoder.sv
module isa_io_decoder #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int WAIT_W    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              dma_cycle_i,
  input  logic              rd_strobe_ni,
  input  logic              wr_strobe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wide_claim_no,
  output logic              chan_ready_o,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_span_i,
  input  logic              cfg_wide_en_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic              hit;
  logic [ADDR_W-1:0] offset;
  logic              rd_fall, wr_fall, idle, done;

  isa_io_window #(.ADDR_W(ADDR_W)) u_window (
    .addr_i    (io_addr_i),
    .base_i    (cfg_base_i),
    .span_i    (cfg_span_i),
    .dma_i     (dma_cycle_i),
    .wide_en_i (cfg_wide_en_i),
    .hit_o     (hit),
    .offset_o  (offset),
    .claim_no  (wide_claim_no)
  );

  isa_io_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_ni     (rd_strobe_ni),
    .wr_ni     (wr_strobe_ni),
    .rd_fall_o (rd_fall),
    .wr_fall_o (wr_fall),
    .idle_o    (idle)
  );

  isa_io_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_fall_i   (rd_fall),
    .wr_fall_i   (wr_fall),
    .idle_i      (idle),
    .hit_i       (hit),
    .offset_i    (offset),
    .wdata_i     (data_i),
    .wait_i      (cfg_wait_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .rdata_o     (data_o),
    .done_o      (done)
  );

  // ready drops combinationally on a qualified strobe, before sync latency
  assign chan_ready_o = !(hit && (!rd_strobe_ni || !wr_strobe_ni) && !done);
  assign data_oe_o    = hit && !rd_strobe_ni;

  // R3: forced 8-bit mode never claims 16-bit width
  a_r3_no_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wide_en_i |-> wide_claim_no);
  // R6: DMA cycles never claim, stall or drive
  a_r6_dma_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_cycle_i |-> chan_ready_o && wide_claim_no && !data_oe_o);
  // R7: ready is low while the register access is in flight
  a_r7_low_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_o && !rd_strobe_ni && hit) |-> !chan_ready_o);
endmodule

// File: tb/isa_io_decoder_bench.sv
`timescale 1ns/1ps
module isa_io_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  io_addr_i = '0;
  logic        dma_cycle_i = 1'b1;
  logic        rd_strobe_ni = 1'b1;
  logic        wr_strobe_ni = 1'b1;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o, wide_claim_no, chan_ready_o;
  logic [9:0]  cfg_base_i = 10'h300;
  logic [9:0]  cfg_span_i = 10'h020;
  logic        cfg_wide_en_i = 1'b1;
  logic [3:0]  cfg_wait_i = '0;
  logic [9:0]  reg_addr_o;
  logic [15:0] reg_wdata_o;
  logic        reg_we_o, reg_re_o;
  logic [15:0] reg_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  isa_io_decoder u_isa_io_decoder (.*);

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [15:0] data;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] rf [0:1023];
  logic [15:0] shadow [0:1023];
  int          checks = 0;
  int          errors = 0;

  initial for (int i = 0; i < 1024; i++) begin
    rf[i]     = 16'(i * 16'h0101) ^ 16'h5a5a;
    shadow[i] = 16'(i * 16'h0101) ^ 16'h5a5a;
  end

  // register-file stub with one-cycle read latency
  always @(posedge clk_i) begin
    if (reg_we_o) rf[reg_addr_o] <= reg_wdata_o;
    if (reg_re_o) reg_rdata_i <= rf[reg_addr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare on every register pulse
  always @(negedge clk_i) begin
    if (rst_ni && (reg_re_o || reg_we_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R9", "unexpected register pulse", int'(reg_addr_o), 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(reg_we_o == it.wr, it.wr ? "R5" : "R4", "access kind",
            int'(reg_we_o), int'(it.wr));
        chk(reg_addr_o == it.addr, it.wr ? "R5" : "R4", "register offset",
            int'(reg_addr_o), int'(it.addr));
        if (it.wr)
          chk(reg_wdata_o == it.data, "R5", "write data",
              int'(reg_wdata_o), int'(it.data));
      end
    end
  end

  function automatic bit in_win(input logic [9:0] a, input bit dma);
    logic [9:0] off;
    off = a - cfg_base_i;
    return !dma && (off < cfg_span_i);
  endfunction

  task automatic io_access(input bit wr, input logic [9:0] a, input bit dma,
                           input logic [15:0] d, output int low);
    bit         hit;
    logic [9:0] off;
    bit         claim_exp;
    hit = in_win(a, dma);
    off = a - cfg_base_i;
    claim_exp = !(hit && cfg_wide_en_i);
    @(negedge clk_i);
    io_addr_i = a; dma_cycle_i = dma; data_i = d;
    @(negedge clk_i);
    chk(wide_claim_no == claim_exp, cfg_wide_en_i ? "R2" : "R3",
        "claim before strobe", int'(wide_claim_no), int'(claim_exp));
    if (hit) begin
      exp_q.push_back('{wr: wr, addr: off, data: d});
      if (wr) shadow[off] = d;
    end
    if (wr) wr_strobe_ni = 1'b0; else rd_strobe_ni = 1'b0;
    #1;
    chk(chan_ready_o == !hit, hit ? "R7" : "R6", "ready at strobe",
        int'(chan_ready_o), int'(!hit));
    chk(wide_claim_no == claim_exp, "R2", "claim under strobe",
        int'(wide_claim_no), int'(claim_exp));
    low = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (chan_ready_o) break;
      low++;
    end
    if (hit && !wr) begin
      chk(data_o == shadow[off], "R4", "read data", int'(data_o), int'(shadow[off]));
      chk(data_oe_o == 1'b1, "R4", "read drive enable", int'(data_oe_o), 1);
    end
    if (!hit) chk(low == 0, "R6", "ready low cycles", low, 0);
    repeat (8) begin
      @(negedge clk_i);
      if (!chan_ready_o) begin
        chk(1'b0, "R7", "ready fell again while held", 0, 1);
        break;
      end
    end
    wr_strobe_ni = 1'b1; rd_strobe_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(exp_q.size() == 0, wr ? "R5" : "R4", "pending expected pulses",
        exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int l0, l1, l3, dummy;
    repeat (3) @(negedge clk_i);
    chk(chan_ready_o == 1'b1, "R7", "reset ready", int'(chan_ready_o), 1);
    chk(wide_claim_no == 1'b1, "R1", "reset claim", int'(wide_claim_no), 1);
    chk(!reg_re_o && !reg_we_o, "R6", "reset pulses", int'({reg_re_o, reg_we_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R5 then R4: write and read back inside the window
    io_access(1'b1, 10'h305, 1'b0, 16'hbeef, dummy);
    io_access(1'b0, 10'h305, 1'b0, 16'h0, dummy);
    io_access(1'b0, 10'h300, 1'b0, 16'h0, dummy);
    // R1: last port in, first port past the end out, port below base out
    io_access(1'b0, 10'h31f, 1'b0, 16'h0, dummy);
    io_access(1'b0, 10'h320, 1'b0, 16'h0, dummy);
    io_access(1'b1, 10'h2ff, 1'b0, 16'h1111, dummy);
    // R6: DMA cycle blocks decode
    io_access(1'b1, 10'h305, 1'b1, 16'h2222, dummy);
    io_access(1'b0, 10'h305, 1'b0, 16'h0, dummy);
    // R3: forced 8-bit mode
    cfg_wide_en_i = 1'b0;
    io_access(1'b1, 10'h310, 1'b0, 16'hc0de, dummy);
    io_access(1'b0, 10'h310, 1'b0, 16'h0, dummy);
    cfg_wide_en_i = 1'b1;
    // R8: wait cycles lengthen the ready-low phase one for one
    cfg_wait_i = 4'd0; io_access(1'b0, 10'h301, 1'b0, 16'h0, l0);
    cfg_wait_i = 4'd1; io_access(1'b0, 10'h301, 1'b0, 16'h0, l1);
    cfg_wait_i = 4'd3; io_access(1'b0, 10'h301, 1'b0, 16'h0, l3);
    chk(l1 - l0 == 1, "R8", "wait=1 extra cycles", l1 - l0, 1);
    chk(l3 - l0 == 3, "R8", "wait=3 extra cycles", l3 - l0, 3);
    cfg_wait_i = 4'd2; io_access(1'b1, 10'h302, 1'b0, 16'h7777, dummy);
    cfg_wait_i = 4'd0;
    // R1: zero span matches nothing
    cfg_span_i = 10'h000;
    io_access(1'b1, 10'h300, 1'b0, 16'h3333, dummy);
    // R1: window wraps past 0x3FF
    cfg_base_i = 10'h3f0; cfg_span_i = 10'h020;
    io_access(1'b1, 10'h005, 1'b0, 16'h4444, dummy);
    io_access(1'b0, 10'h005, 1'b0, 16'h0, dummy);
    io_access(1'b0, 10'h010, 1'b0, 16'h0, dummy);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule